// File: doc/BRIEF.md
# Accumulator Microprocessor Core

This block is a small stored-program processor built around a single accumulator. Code and data share one memory, reached through a synchronous single-port interface: the core presents an address with a read strobe and takes the data one cycle later, or presents an address, write data and a write strobe to store. Each instruction is one 16-bit word. Bits [15:12] hold the operation and bits [11:0] hold a memory address called the operand.

Instructions run strictly one after another under a multi-cycle sequencer. A fetch reads the word at the program counter. A decode cycle latches it into the instruction register and moves the counter on by two. An execute cycle then performs the operation, and loads, additions and subtractions take one more cycle to write the accumulator. The core is meant for small control programs. The stop instruction parks it with a halted flag raised until the next reset.

Top module: `accum_core`

## Requirements
- R1: While reset is held the core keeps halted and mem_we low and drives mem_addr 0. After release, the first fetch reads address 0 and the accumulator starts from zero.
- R2: An instruction word carries its opcode in bits [15:12] and its operand address in bits [11:0]. Without a branch, successive fetches read addresses 0, 2, 4 and onwards.
- R3: Opcode 0000 copies mem[operand] into the accumulator. Opcode 0001 writes the accumulator to mem[operand], and this is the only opcode that raises mem_we.
- R4: Opcode 0010 adds mem[operand] to the accumulator and opcode 0011 subtracts it. Both wrap modulo 2^16 (0x7FFF+1 gives 0x8000, and 0-1 gives 0xFFFF).
- R5: Opcode 0100 moves the program counter to the operand without condition.
- R6: Opcode 0101 jumps to the operand when accumulator bit 15 is 0, which includes zero. Otherwise execution falls through to the next word.
- R7: Opcode 0110 jumps to the operand when the accumulator is non-zero. Otherwise execution falls through.
- R8: Opcode 0111 raises halted three clock edges after its fetch began. halted then stays high with mem_re and mem_we low until reset.
- R9: Opcodes 1000 to 1111 leave the accumulator and memory unchanged and only advance the program counter.
- R10: Load, add and subtract take four cycles. Store, every jump form and the no-operations take three. mem_re and mem_we are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory word address (program counter or operand) |
| mem_re | output | 1 | Read strobe; data is expected on mem_rdata one cycle later |
| mem_we | output | 1 | Write strobe for a store |
| mem_wdata | output | 16 | Accumulator value written on a store |
| mem_rdata | input | 16 | Read data from the synchronous memory |
| halted | output | 1 | High once the stop instruction has executed |

## Verification
Some rules are checked on every cycle: the read and write strobes never overlap, only a store can write, halted is sticky and silences the memory port, a no-operation leaves the accumulator alone, and the program counter holds when nothing moves it. The same cycle-by-cycle checks confirm that a taken jump lands on its operand and that a load writes back exactly the word it read. The bench scenarios are the only way to show the arithmetic results, including wrap-around, and the fall-through of untaken conditional branches at the sign and zero boundaries. They also show the per-instruction cycle counts, taken from whole programs that end in a stop, and that a fresh reset clears an accumulator left dirty by an earlier run.

// File: rtl/accum_pkg.sv
package accum_pkg;

   // operation codes carried in the top bits of an instruction word
   localparam logic [3:0] OP_LOAD    = 4'h0;
   localparam logic [3:0] OP_STORE   = 4'h1;
   localparam logic [3:0] OP_ADD     = 4'h2;
   localparam logic [3:0] OP_SUB     = 4'h3;
   localparam logic [3:0] OP_JUMP    = 4'h4;
   localparam logic [3:0] OP_JUMP_GE = 4'h5;
   localparam logic [3:0] OP_JUMP_NZ = 4'h6;
   localparam logic [3:0] OP_STOP    = 4'h7;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_DECODE,
      ST_EXEC,
      ST_WBACK,
      ST_HALT
   } cpu_state_e;

   typedef enum logic [1:0] {
      ALU_PASS,
      ALU_ADD,
      ALU_SUB
   } alu_fn_e;

endpackage

// File: rtl/accum_pc.sv
module accum_pc #(
   parameter int ADDR_W = 12,
   parameter int STEP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              load,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc
);

   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   generate
      if (STEP < 1 || STEP >= (1 << ADDR_W)) begin : g_bad_step
         $error("accum_pc: STEP out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         pc <= '0;
      else if (load)
         pc <= target;
      else if (adv)
         pc <= pc + STEP_V;
   end

   // R2: the counter moves only on an advance or a load
   p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !load) |=> $stable(pc));

endmodule

// File: rtl/accum_alu.sv
module accum_alu
   import accum_pkg::*;
#(
   parameter int DATA_W            = 16,
   parameter bit SUB_BY_COMPLEMENT = 1'b1
) (
   input  alu_fn_e           fn,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] y
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] diff;

   assign sum = acc + opnd;

   generate
      if (SUB_BY_COMPLEMENT) begin : g_sub_cpl
         assign diff = acc + ~opnd + ONE;
      end else begin : g_sub_direct
         assign diff = acc - opnd;
      end
   endgenerate

   always_comb begin
      case (fn)
         ALU_ADD: y = sum;
         ALU_SUB: y = diff;
         default: y = opnd;
      endcase
   end

   // R4: a difference plus the subtrahend gives back the minuend
   always_comb begin
      if (fn == ALU_SUB)
         p_sub_inverse_r4: assert (DATA_W'(y + opnd) == acc);
   end

endmodule

// File: rtl/accum_ctrl.sv
module accum_ctrl
   import accum_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] ir_op,
   input  logic             acc_zero,
   input  logic             acc_neg,
   output cpu_state_e       state,
   output logic             ir_load,
   output logic             pc_adv,
   output logic             pc_load,
   output logic             acc_load,
   output alu_fn_e          alu_fn,
   output logic             sel_opnd,
   output logic             mem_re,
   output logic             mem_we,
   output logic             halted
);

   generate
      if (OPC_W < 3) begin : g_bad_opc
         $error("accum_ctrl: OPC_W must hold eight operations");
      end
   endgenerate

   localparam logic [OPC_W-1:0] C_LOAD  = OPC_W'(OP_LOAD);
   localparam logic [OPC_W-1:0] C_STORE = OPC_W'(OP_STORE);
   localparam logic [OPC_W-1:0] C_ADD   = OPC_W'(OP_ADD);
   localparam logic [OPC_W-1:0] C_SUB   = OPC_W'(OP_SUB);
   localparam logic [OPC_W-1:0] C_JMP   = OPC_W'(OP_JUMP);
   localparam logic [OPC_W-1:0] C_JGE   = OPC_W'(OP_JUMP_GE);
   localparam logic [OPC_W-1:0] C_JNZ   = OPC_W'(OP_JUMP_NZ);
   localparam logic [OPC_W-1:0] C_STOP  = OPC_W'(OP_STOP);

   cpu_state_e state_nx;
   logic       needs_read;

   assign needs_read = (ir_op == C_LOAD) || (ir_op == C_ADD) || (ir_op == C_SUB);

   always_ff @(posedge clk) begin
      if (!rst_n)
         state <= ST_FETCH;
      else
         state <= state_nx;
   end

   always_comb begin
      state_nx = state;
      ir_load  = 1'b0;
      pc_adv   = 1'b0;
      pc_load  = 1'b0;
      acc_load = 1'b0;
      alu_fn   = ALU_PASS;
      sel_opnd = 1'b0;
      mem_re   = 1'b0;
      mem_we   = 1'b0;
      case (state)
         ST_FETCH: begin
            mem_re   = 1'b1;
            state_nx = ST_DECODE;
         end
         ST_DECODE: begin
            ir_load  = 1'b1;
            pc_adv   = 1'b1;
            state_nx = ST_EXEC;
         end
         ST_EXEC: begin
            state_nx = ST_FETCH;
            if (needs_read) begin
               sel_opnd = 1'b1;
               mem_re   = 1'b1;
               state_nx = ST_WBACK;
            end else if (ir_op == C_STORE) begin
               sel_opnd = 1'b1;
               mem_we   = 1'b1;
            end else if (ir_op == C_JMP) begin
               pc_load = 1'b1;
            end else if (ir_op == C_JGE) begin
               pc_load = !acc_neg;
            end else if (ir_op == C_JNZ) begin
               pc_load = !acc_zero;
            end else if (ir_op == C_STOP) begin
               state_nx = ST_HALT;
            end
         end
         ST_WBACK: begin
            acc_load = 1'b1;
            if (ir_op == C_ADD)
               alu_fn = ALU_ADD;
            else if (ir_op == C_SUB)
               alu_fn = ALU_SUB;
            state_nx = ST_FETCH;
         end
         default: begin
            state_nx = ST_HALT;
         end
      endcase
   end

   assign halted = (state == ST_HALT);

   // R10: a write-back cycle always follows an execute cycle
   p_wback_after_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WBACK) |-> ($past(state) == ST_EXEC));

endmodule

// File: rtl/accum_core.sv
module accum_core
   import accum_pkg::*;
#(
   parameter int DATA_W            = 16,
   parameter int ADDR_W            = 12,
   parameter int OPC_W             = 4,
   parameter int PC_STEP           = 2,
   parameter bit SUB_BY_COMPLEMENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted
);

   localparam int INSN_W = OPC_W + ADDR_W;
   localparam logic [OPC_W-1:0] LAST_OP = OPC_W'(OP_STOP);

   generate
      if (DATA_W < INSN_W) begin : g_bad_width
         $error("accum_core: DATA_W too small for one instruction word");
      end
   endgenerate

   cpu_state_e        state;
   logic              ir_load;
   logic              pc_adv;
   logic              pc_load;
   logic              acc_load;
   alu_fn_e           alu_fn;
   logic              sel_opnd;
   logic [INSN_W-1:0] ir;
   logic [OPC_W-1:0]  ir_op;
   logic [ADDR_W-1:0] ir_opnd;
   logic [ADDR_W-1:0] pc;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] alu_y;
   logic              acc_zero;
   logic              acc_neg;

   // instruction register
   always_ff @(posedge clk) begin
      if (!rst_n)
         ir <= '0;
      else if (ir_load)
         ir <= mem_rdata[INSN_W-1:0];
   end

   assign ir_op   = ir[INSN_W-1 -: OPC_W];
   assign ir_opnd = ir[ADDR_W-1:0];

   // accumulator
   always_ff @(posedge clk) begin
      if (!rst_n)
         acc <= '0;
      else if (acc_load)
         acc <= alu_y;
   end

   assign acc_zero = (acc == '0);
   assign acc_neg  = acc[DATA_W-1];

   accum_ctrl #(
      .OPC_W (OPC_W)
   ) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ir_op    (ir_op),
      .acc_zero (acc_zero),
      .acc_neg  (acc_neg),
      .state    (state),
      .ir_load  (ir_load),
      .pc_adv   (pc_adv),
      .pc_load  (pc_load),
      .acc_load (acc_load),
      .alu_fn   (alu_fn),
      .sel_opnd (sel_opnd),
      .mem_re   (mem_re),
      .mem_we   (mem_we),
      .halted   (halted)
   );

   accum_pc #(
      .ADDR_W (ADDR_W),
      .STEP   (PC_STEP)
   ) i_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (pc_adv),
      .load   (pc_load),
      .target (ir_opnd),
      .pc     (pc)
   );

   accum_alu #(
      .DATA_W            (DATA_W),
      .SUB_BY_COMPLEMENT (SUB_BY_COMPLEMENT)
   ) i_alu (
      .fn   (alu_fn),
      .acc  (acc),
      .opnd (mem_rdata),
      .y    (alu_y)
   );

   assign mem_addr  = sel_opnd ? ir_opnd : pc;
   assign mem_wdata = acc;

   // R10: read and write strobes are exclusive
   p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));

   // R3: only a store instruction may write memory
   p_we_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (ir_op == OP_STORE[OPC_W-1:0]));

   // R3: a load writes back exactly the word read
   p_load_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WBACK && ir_op == OP_LOAD[OPC_W-1:0]) |=> (acc == $past(mem_rdata)));

   // R5: unconditional jump lands on the operand
   p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && ir_op == OP_JUMP[OPC_W-1:0]) |=> (pc == $past(ir_opnd)));

   // R6: greater-or-equal jump taken on a non-negative accumulator
   p_jge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && ir_op == OP_JUMP_GE[OPC_W-1:0] && !acc[DATA_W-1])
      |=> (pc == $past(ir_opnd)));

   // R7: non-zero jump taken on a non-zero accumulator
   p_jnz_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && ir_op == OP_JUMP_NZ[OPC_W-1:0] && acc != '0)
      |=> (pc == $past(ir_opnd)));

   // R8: halted is sticky
   p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R8: a halted core leaves memory alone
   p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_re && !mem_we));

   // R9: an unused opcode does not touch the accumulator
   p_nop_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && ir_op > LAST_OP) |=> $stable(acc));

endmodule

// File: tb/test_accum_core.sv
module test_accum_core;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] mem_addr;
   logic        mem_re;
   logic        mem_we;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        halted;

   logic [15:0] mem [0:511];
   int          n_cmp = 0;
   int          n_bad = 0;
   int          wr_cnt = 0;

   always #10 clk = ~clk;

   accum_core i_accum_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_re    (mem_re),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .halted    (halted)
   );

   // synchronous single-port memory model
   always @(posedge clk) begin
      if (mem_we)
         mem[mem_addr[8:0]] <= mem_wdata;
      if (mem_re)
         mem_rdata <= mem[mem_addr[8:0]];
   end

   always @(posedge clk) begin
      if (rst_n && mem_we)
         wr_cnt <= wr_cnt + 1;
   end

   function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] s);
      return {op, s};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic hold_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 512; i++)
         mem[i] = 16'h0000;
   endtask

   task automatic run(output int n);
      @(negedge clk);
      wr_cnt = 0;
      rst_n  = 1'b1;
      n = 0;
      while (!halted && n < 600) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      hold_reset();
      chk("R1", "halted in reset", 32'(halted), 0);
      chk("R1", "we in reset", 32'(mem_we), 0);
      chk("R1", "addr in reset", 32'(mem_addr), 0);
   endtask

   task automatic t_sequence();
      hold_reset();
      for (int k = 0; k < 4; k++)
         mem[2*k] = ins(4'h8 + 4'(k), 12'h140);
      mem[8] = ins(4'h7, 12'h000);
      rst_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         chk("R2", "fetch address", 32'(mem_addr), 32'(2*k));
         chk("R10", "fetch strobe", 32'(mem_re), 1);
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic t_arith();
      int n;
      hold_reset();
      mem[12'h000] = ins(4'h0, 12'h100);
      mem[12'h002] = ins(4'h2, 12'h102);
      mem[12'h004] = ins(4'h1, 12'h104);
      mem[12'h006] = ins(4'h3, 12'h106);
      mem[12'h008] = ins(4'h1, 12'h108);
      mem[12'h00A] = ins(4'h7, 12'h000);
      mem[12'h100] = 16'd5;
      mem[12'h102] = 16'd7;
      mem[12'h106] = 16'd20;
      run(n);
      chk("R4", "add result", 32'(mem[12'h104]), 32'h000C);
      chk("R4", "sub to negative", 32'(mem[12'h108]), 32'hFFF8);
      chk("R10", "arith cycles", 32'(n), 21);
      chk("R3", "store count", 32'(wr_cnt), 2);
   endtask

   task automatic t_wrap();
      int n;
      hold_reset();
      mem[12'h000] = ins(4'h0, 12'h110);
      mem[12'h002] = ins(4'h2, 12'h112);
      mem[12'h004] = ins(4'h1, 12'h114);
      mem[12'h006] = ins(4'h0, 12'h116);
      mem[12'h008] = ins(4'h3, 12'h112);
      mem[12'h00A] = ins(4'h1, 12'h118);
      mem[12'h00C] = ins(4'h7, 12'h000);
      mem[12'h110] = 16'h7FFF;
      mem[12'h112] = 16'h0001;
      run(n);
      chk("R4", "positive wrap", 32'(mem[12'h114]), 32'h8000);
      chk("R4", "zero minus one", 32'(mem[12'h118]), 32'hFFFF);
      chk("R10", "wrap cycles", 32'(n), 25);
   endtask

   task automatic t_acc_reset();
      int n;
      hold_reset();
      mem[12'h000] = ins(4'h1, 12'h120);
      mem[12'h002] = ins(4'h7, 12'h000);
      mem[12'h120] = 16'h5555;
      run(n);
      chk("R1", "accumulator cleared", 32'(mem[12'h120]), 0);
      chk("R10", "store cycles", 32'(n), 6);
   endtask

   task automatic t_jump();
      int n;
      hold_reset();
      mem[12'h000] = ins(4'h4, 12'h008);
      mem[12'h002] = ins(4'h0, 12'h100);
      mem[12'h004] = ins(4'h1, 12'h130);
      mem[12'h006] = ins(4'h7, 12'h000);
      mem[12'h008] = ins(4'h0, 12'h102);
      mem[12'h00A] = ins(4'h1, 12'h132);
      mem[12'h00C] = ins(4'h7, 12'h000);
      mem[12'h100] = 16'h1111;
      mem[12'h102] = 16'h2222;
      mem[12'h130] = 16'hDEAD;
      run(n);
      chk("R5", "skipped store", 32'(mem[12'h130]), 32'hDEAD);
      chk("R5", "target store", 32'(mem[12'h132]), 32'h2222);
      chk("R5", "jump cycles", 32'(n), 13);
   endtask

   task automatic t_loop();
      int n;
      hold_reset();
      mem[12'h000] = ins(4'h0, 12'h100);
      mem[12'h002] = ins(4'h3, 12'h102);
      mem[12'h004] = ins(4'h1, 12'h100);
      mem[12'h006] = ins(4'h6, 12'h000);
      mem[12'h008] = ins(4'h7, 12'h000);
      mem[12'h100] = 16'd3;
      mem[12'h102] = 16'd1;
      run(n);
      chk("R7", "countdown result", 32'(mem[12'h100]), 0);
      chk("R7", "loop cycles", 32'(n), 45);
      chk("R7", "loop stores", 32'(wr_cnt), 3);
   endtask

   task automatic t_jge(input logic [15:0] val, input logic [15:0] exp, input string what);
      int n;
      hold_reset();
      mem[12'h000] = ins(4'h0, 12'h100);
      mem[12'h002] = ins(4'h5, 12'h00A);
      mem[12'h004] = ins(4'h0, 12'h102);
      mem[12'h006] = ins(4'h1, 12'h104);
      mem[12'h008] = ins(4'h7, 12'h000);
      mem[12'h00A] = ins(4'h0, 12'h106);
      mem[12'h00C] = ins(4'h1, 12'h104);
      mem[12'h00E] = ins(4'h7, 12'h000);
      mem[12'h100] = val;
      mem[12'h102] = 16'h00AA;
      mem[12'h106] = 16'h00BB;
      run(n);
      chk("R6", what, 32'(mem[12'h104]), 32'(exp));
      chk("R6", "branch program cycles", 32'(n), 17);
   endtask

   task automatic t_nop();
      int n;
      hold_reset();
      mem[12'h000] = ins(4'h0, 12'h100);
      for (int k = 0; k < 8; k++)
         mem[2 + 2*k] = ins(4'h8 + 4'(k), 12'h140);
      mem[12'h012] = ins(4'h1, 12'h102);
      mem[12'h014] = ins(4'h7, 12'h000);
      mem[12'h100] = 16'h1234;
      mem[12'h140] = 16'h0F0F;
      run(n);
      chk("R9", "accumulator kept", 32'(mem[12'h102]), 32'h1234);
      chk("R9", "operand word kept", 32'(mem[12'h140]), 32'h0F0F);
      chk("R9", "writes", 32'(wr_cnt), 1);
      chk("R9", "nop cycles", 32'(n), 34);
   endtask

   task automatic t_halt();
      int n;
      int bad;
      hold_reset();
      mem[12'h000] = ins(4'h7, 12'h000);
      run(n);
      chk("R8", "stop latency", 32'(n), 3);
      bad = 0;
      for (int k = 0; k < 20; k++) begin
         if (!halted || mem_re || mem_we)
            bad++;
         @(negedge clk);
      end
      chk("R8", "quiet halt cycles violated", 32'(bad), 0);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "halted cleared by reset", 32'(halted), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      t_reset();
      t_sequence();
      t_arith();
      t_wrap();
      t_acc_reset();
      t_jump();
      t_loop();
      t_jge(16'h0005, 16'h00BB, "positive taken");
      t_jge(16'h0000, 16'h00BB, "zero taken");
      t_jge(16'h8000, 16'h00AA, "negative falls through");
      t_nop();
      t_halt();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule